// File: doc/BRIEF.md
# Push-Button Gesture Classifier

This block watches one mechanical push-button and, on request, sorts what the user does with it into one of four outcomes: nothing pressed, a single click, a double click or a long hold. The raw pin is first brought into the clock domain by a two-flop synchronizer. A stable-count filter then removes contact bounce. A free-running prescaler and tick counter supply the time base. A small state machine compares that counter against computed deadlines.

A one-cycle `start` strobe opens a classification. If the button is already up at that moment, the block answers "none" at once. Otherwise it waits for either a release or a hold deadline, which is derived from the `hold_ms` input. After a release it restarts timing from the release and opens a fixed double-click window. A second press inside that window gives a double click. If the window runs out, the result is a single click. The outcome appears as a one-cycle `result_valid` pulse with a 2-bit code.

Top module: `btn_gesture_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `result_valid` is low and no classification is in progress.
- R2: When `start` is seen while idle and the filtered button is released, `result_valid` pulses within two clock cycles with code 2'b00 (none), without waiting for any deadline.
- R3: A tick occurs once every 2^DIV_LOG2 clock cycles. The hold deadline is (CLK_KHZ × ms) >> DIV_LOG2 ticks after the `start` cycle, taken modulo 2^TICK_W. The tick counter only ever steps by one.
- R4: If the filtered button is still pressed when the tick counter equals the hold deadline, the result is code 2'b11 (hold).
- R5: On a release before the hold deadline, timing restarts from the current tick with a window of (CLK_KHZ × WIN_MS) >> DIV_LOG2 ticks. If that window expires with no new press, the result is code 2'b01 (single).
- R6: A new filtered press inside the double-click window gives code 2'b10 (double) on the following cycle.
- R7: A `hold_ms` value of zero is treated as DEF_MS milliseconds.
- R8: A `start` strobe that arrives while a classification is running has no effect. Exactly one result is produced, with the timing of the first strobe.
- R9: A raw button level that lasts fewer than DEB_CNT consecutive synchronized cycles does not change the filtered button and does not affect any result.
- R10: `result_valid` is high for exactly one clock per classification, and the block then returns to idle.
- R11: Deadline comparison is an equality test modulo 2^TICK_W, so a deadline that lies past a counter wrap still expires after the programmed number of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_raw | input | 1 | Unsynchronized button level, 1 = pressed |
| start | input | 1 | One-cycle strobe that opens a classification |
| hold_ms | input | MS_W | Hold threshold in milliseconds, 0 selects DEF_MS |
| result_valid | output | 1 | One-cycle pulse marking a result |
| result_code | output | 2 | 00 none, 01 single, 10 double, 11 hold |

## Verification
A corrupted deadline register or tick counter shows at the ports as a result arriving at the wrong time. The error is usually a whole tick period or more, and a miss of an equality compare delays the result by a full counter wrap. The bench therefore bounds every result's latency on both sides. A state machine stuck in the wrong state shows as a wrong code, a missing pulse or a second pulse, typically within one double-click window of the stimulus. A faulty filter shows the same way, because a glitch turns a hold into a single or a double click within a few cycles of the glitch.

// File: rtl/btn_gesture_pkg.sv
package btn_gesture_pkg;

   typedef enum logic [1:0] {
      GEST_NONE   = 2'b00,
      GEST_SINGLE = 2'b01,
      GEST_DOUBLE = 2'b10,
      GEST_HOLD   = 2'b11
   } gesture_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DOWN = 2'd1,
      ST_GAP  = 2'd2
   } cls_state_e;

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
   parameter int DEB_CNT = 48000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic level_o
);
   localparam int CNT_W = (DEB_CNT > 1) ? $clog2(DEB_CNT + 1) : 1;

   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[0], raw_i};
   end

   generate
      if (DEB_CNT <= 1) begin : g_bypass
         assign level_o = sync_q[1];
      end else begin : g_filter
         logic [CNT_W-1:0] cnt_q;
         logic             lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               lvl_q <= 1'b0;
            end else if (sync_q[1] == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_W'(DEB_CNT - 1)) begin
               cnt_q <= '0;
               lvl_q <= sync_q[1];
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign level_o = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/btn_tick_gen.sv
module btn_tick_gen #(
   parameter int DIV_LOG2 = 10,
   parameter int TICK_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TICK_W-1:0] tick_cnt_o
);
   logic [TICK_W-1:0] cnt_q;

   generate
      if (DIV_LOG2 == 0) begin : g_nodiv
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_div
         logic [DIV_LOG2-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
               cnt_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
               if (&pre_q) cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign tick_cnt_o = cnt_q;
endmodule

// File: rtl/btn_classify_fsm.sv
module btn_classify_fsm
   import btn_gesture_pkg::*;
#(
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              btn_i,
   input  logic [TICK_W-1:0] tick_i,
   input  logic [TICK_W-1:0] hold_ticks_i,
   input  logic [TICK_W-1:0] win_ticks_i,
   output logic              busy_o,
   output logic              valid_o,
   output logic [1:0]        code_o
);
   cls_state_e        state_q;
   logic [TICK_W-1:0] due_q;
   logic              hit;

   assign hit = (tick_i == due_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         due_q   <= '0;
         valid_o <= 1'b0;
         code_o  <= GEST_NONE;
      end else begin
         valid_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (!btn_i) begin
                     valid_o <= 1'b1;
                     code_o  <= GEST_NONE;
                  end else begin
                     due_q   <= tick_i + hold_ticks_i;
                     state_q <= ST_DOWN;
                  end
               end
            end
            ST_DOWN: begin
               if (!btn_i) begin
                  due_q   <= tick_i + win_ticks_i;
                  state_q <= ST_GAP;
               end else if (hit) begin
                  valid_o <= 1'b1;
                  code_o  <= GEST_HOLD;
                  state_q <= ST_IDLE;
               end
            end
            ST_GAP: begin
               if (btn_i) begin
                  valid_o <= 1'b1;
                  code_o  <= GEST_DOUBLE;
                  state_q <= ST_IDLE;
               end else if (hit) begin
                  valid_o <= 1'b1;
                  code_o  <= GEST_SINGLE;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/btn_gesture_top.sv
module btn_gesture_top #(
   parameter int CLK_KHZ  = 48000,
   parameter int DIV_LOG2 = 10,
   parameter int TICK_W   = 16,
   parameter int MS_W     = 16,
   parameter int DEF_MS   = 1000,
   parameter int WIN_MS   = 500,
   parameter int DEB_CNT  = 48000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            btn_raw,
   input  logic            start,
   input  logic [MS_W-1:0] hold_ms,
   output logic            result_valid,
   output logic [1:0]      result_code
);
   localparam int PROD_W = MS_W + 32;
   localparam longint WIN_FULL = (longint'(CLK_KHZ) * longint'(WIN_MS)) >>> DIV_LOG2;
   localparam logic [TICK_W-1:0] WIN_TICKS = TICK_W'(WIN_FULL);

   if (TICK_W < 4 || TICK_W > 32) begin : g_bad_tick_w
      $error("TICK_W out of range");
   end
   if (DIV_LOG2 < 0 || DIV_LOG2 > 24) begin : g_bad_div
      $error("DIV_LOG2 out of range");
   end
   if (CLK_KHZ < 1 || DEF_MS < 1 || WIN_MS < 1 || MS_W < 1) begin : g_bad_cfg
      $error("timing parameters must be positive");
   end

   logic              btn_f;
   logic              busy;
   logic [TICK_W-1:0] tick_cnt;
   logic [MS_W-1:0]   ms_eff;
   logic [PROD_W-1:0] prod;
   logic [TICK_W-1:0] hold_ticks;

   assign ms_eff     = (hold_ms == '0) ? MS_W'(DEF_MS) : hold_ms;
   assign prod       = PROD_W'(ms_eff) * PROD_W'(CLK_KHZ);
   assign hold_ticks = TICK_W'(prod >> DIV_LOG2);

   btn_debounce #(.DEB_CNT(DEB_CNT)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (btn_raw),
      .level_o (btn_f)
   );

   btn_tick_gen #(.DIV_LOG2(DIV_LOG2), .TICK_W(TICK_W)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_cnt_o (tick_cnt)
   );

   btn_classify_fsm #(.TICK_W(TICK_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .btn_i        (btn_f),
      .tick_i       (tick_cnt),
      .hold_ticks_i (hold_ticks),
      .win_ticks_i  (WIN_TICKS),
      .busy_o       (busy),
      .valid_o      (result_valid),
      .code_o       (result_code)
   );
endmodule

// File: rtl/btn_gesture_chk.sv
module btn_gesture_chk #(
   parameter int TICK_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              btn_f,
   input logic              busy,
   input logic [TICK_W-1:0] tick_cnt,
   input logic              result_valid,
   input logic [1:0]        result_code
);
   assert_valid_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   assert_none_at_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !btn_f) |=> (result_valid && result_code == 2'b00));

   assert_tick_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_cnt != $past(tick_cnt)) |-> (tick_cnt == TICK_W'($past(tick_cnt) + 1'b1)));

   assert_hold_pressed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && result_code == 2'b11) |-> $past(btn_f));

   assert_double_pressed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && result_code == 2'b10) |-> $past(btn_f));

   assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || result_valid));

   assert_idle_after_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && result_code != 2'b00) |-> !busy);
endmodule

bind btn_gesture_top btn_gesture_chk #(.TICK_W(TICK_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .btn_f        (btn_f),
   .busy         (busy),
   .tick_cnt     (tick_cnt),
   .result_valid (result_valid),
   .result_code  (result_code)
);

// File: tb/tb_btn_gesture_top.sv
`timescale 1ns/1ps
module tb_btn_gesture_top;
   localparam int CLK_KHZ  = 48;
   localparam int DIV_LOG2 = 2;
   localparam int P        = 4;
   localparam int TICK_W   = 14;
   localparam int MS_W     = 16;
   localparam int DEF_MS   = 1000;
   localparam int WIN_MS   = 50;
   localparam int DEB_CNT  = 4;
   localparam int SLK      = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_raw = 1'b0;
   logic start = 1'b0;
   logic [MS_W-1:0] hold_ms = '0;
   logic result_valid;
   logic [1:0] result_code;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int vcount = 0;
   int last_vcyc = 0;
   logic [1:0] last_code = 2'b00;
   int first_hi = 0;
   int hi_run = 0;

   always #5 clk = ~clk;

   btn_gesture_top #(
      .CLK_KHZ(CLK_KHZ), .DIV_LOG2(DIV_LOG2), .TICK_W(TICK_W), .MS_W(MS_W),
      .DEF_MS(DEF_MS), .WIN_MS(WIN_MS), .DEB_CNT(DEB_CNT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .start(start),
      .hold_ms(hold_ms), .result_valid(result_valid), .result_code(result_code)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (result_valid) begin
         vcount    <= vcount + 1;
         last_vcyc <= cyc;
         last_code <= result_code;
         hi_run    <= hi_run + 1;
         if (hi_run >= 1) first_hi <= first_hi + 1;
      end else begin
         hi_run <= 0;
      end
   end

   function automatic int ticks_of(input int ms);
      int m;
      m = (ms == 0) ? DEF_MS : ms;
      return ((CLK_KHZ * m) >> DIV_LOG2) % (1 << TICK_W);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start(output int t0);
      @(negedge clk);
      t0 = cyc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_result(input int n0, input int limit, output bit got);
      got = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (vcount != n0) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   task automatic run_hold(input int ms, input string req);
      int t0, n0, tk, d;
      bit got;
      hold_ms = MS_W'(ms);
      btn_raw = 1'b1;
      idle(20);
      n0 = vcount;
      pulse_start(t0);
      tk = ticks_of(ms);
      wait_result(n0, tk * P + 200, got);
      d = last_vcyc - t0;
      chk(got && last_code == 2'b11, req, last_code, 3);
      chk(d >= (tk - 1) * P && d <= tk * P + SLK, req, d, tk * P);
      btn_raw = 1'b0;
      idle(20);
   endtask

   task automatic run_single(input int ms, input int dn, input string req);
      int t0, tr, n0, tw, d;
      bit got;
      hold_ms = MS_W'(ms);
      btn_raw = 1'b1;
      idle(20);
      n0 = vcount;
      pulse_start(t0);
      idle(dn);
      tr = cyc;
      btn_raw = 1'b0;
      tw = ticks_of(WIN_MS);
      wait_result(n0, tw * P + 200, got);
      d = last_vcyc - tr;
      chk(got && last_code == 2'b01, req, last_code, 1);
      chk(d >= (tw - 1) * P && d <= tw * P + SLK, req, d, tw * P);
      idle(20);
   endtask

   task automatic run_double(input int ms, input int dn, input int gap, input string req);
      int t0, tp, n0, d;
      bit got;
      hold_ms = MS_W'(ms);
      btn_raw = 1'b1;
      idle(20);
      n0 = vcount;
      pulse_start(t0);
      idle(dn);
      btn_raw = 1'b0;
      idle(gap);
      tp = cyc;
      btn_raw = 1'b1;
      wait_result(n0, 200, got);
      d = last_vcyc - tp;
      chk(got && last_code == 2'b10, req, last_code, 2);
      chk(d <= SLK, req, d, SLK);
      btn_raw = 1'b0;
      idle(20);
   endtask

   int t0, n0, k, ms, dn, gp;
   bit got;

   initial begin
      void'($urandom(32'd1234));
      idle(3);
      chk(result_valid == 1'b0, "R1 valid low in reset", result_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(result_valid == 1'b0 && vcount == 0, "R1 valid low after reset", vcount, 0);
      idle(10);

      // R2: button up at start -> none within two cycles
      n0 = vcount;
      pulse_start(t0);
      @(negedge clk);
      chk(vcount == n0 + 1 && last_code == 2'b00, "R2 none at once", last_code, 0);
      chk(last_vcyc - t0 <= 2, "R2 latency", last_vcyc - t0, 2);
      chk(first_hi == 0, "R10 one cycle pulse", first_hi, 0);

      // R9: short glitch does not register as a press
      btn_raw = 1'b1;
      idle(3);
      btn_raw = 1'b0;
      idle(2);
      n0 = vcount;
      pulse_start(t0);
      @(negedge clk);
      chk(vcount == n0 + 1 && last_code == 2'b00, "R9 glitch ignored", last_code, 0);
      idle(20);

      // R3 R4: hold with programmed ms
      run_hold(20, "R4 hold");

      // R8: second start during a hold is ignored
      hold_ms = MS_W'(20);
      btn_raw = 1'b1;
      idle(20);
      n0 = vcount;
      pulse_start(t0);
      idle(100);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_result(n0, ticks_of(20) * P + 200, got);
      chk(got && last_code == 2'b11, "R8 result code", last_code, 3);
      chk(last_vcyc - t0 <= ticks_of(20) * P + SLK, "R8 timing of first start",
          last_vcyc - t0, ticks_of(20) * P);
      idle(300);
      chk(vcount == n0 + 1, "R8 single result", vcount - n0, 1);
      btn_raw = 1'b0;
      idle(20);

      // R9: short release glitch during a hold keeps it a hold
      hold_ms = MS_W'(15);
      btn_raw = 1'b1;
      idle(20);
      n0 = vcount;
      pulse_start(t0);
      idle(50);
      btn_raw = 1'b0;
      idle(2);
      btn_raw = 1'b1;
      wait_result(n0, ticks_of(15) * P + 200, got);
      chk(got && last_code == 2'b11, "R9 release glitch ignored", last_code, 3);
      btn_raw = 1'b0;
      idle(20);

      // R5 single, R6 double, directed
      run_single(30, 100, "R5 single");
      run_double(30, 100, 2000, "R6 double late in window");
      run_double(30, 100, 30, "R6 double early");

      // R7 default hold length
      run_hold(0, "R7 default ms");

      // mixed random rounds, crossing counter wraps (R11)
      for (int r = 0; r < 18; r++) begin
         k = $urandom_range(0, 2);
         if (k == 0) begin
            ms = $urandom_range(5, 40);
            run_hold(ms, "R11 random hold");
         end else if (k == 1) begin
            ms = $urandom_range(30, 60);
            dn = $urandom_range(60, 300);
            run_single(ms, dn, "R5 random single");
         end else begin
            ms = $urandom_range(30, 60);
            dn = $urandom_range(60, 300);
            gp = $urandom_range(40, 2000);
            run_double(ms, dn, gp, "R6 random double");
         end
      end

      chk(first_hi == 0, "R10 no stretched pulse", first_hi, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule